// File: doc/BRIEF.md
# Split Nibble Register File

This block stores eight 4-bit registers and offers two views of them. In the fine view, eight nibble read ports and eight nibble write ports each pick registers with a one-hot select vector rather than a binary address. In the coarse view, one extra read port and one extra write port treat the eight registers as a single 32-bit word, with register i in bits 4i+3 down to 4i. Reads are combinational. Writes land on the next rising clock edge.

Write-through forwarding is selected by a parameter and is on by default. With forwarding on, any read of a register that is being written in the same cycle returns the data about to be stored, not the old contents. When several writers target one register in one cycle, a fixed priority decides the value. Nibble write ports beat the word write port, and among nibble ports the lowest-numbered port wins. Reset is synchronous and active high.

The usual client is an issue stage that tracks operands with bit-vectors. Each one-hot select maps directly to a register with no address decoder in between. The word ports let the whole set be saved or restored in a single cycle.

Top module: `snrf_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, every register becomes 0, so the word read returns 0x00000000 in the following cycle.
- R2: When bit p*8+i of `nwr_sel` is set at a rising edge, register i takes nibble p of `nwr_data` (bits 4p+3:4p). A port with several select bits set writes every selected register. A nibble read of register i in a later cycle returns that value.
- R3: A nibble read port p whose select bits `nrd_sel[p*8+7:p*8]` are all zero drives 0 on nibble p of `nrd_data`.
- R4: When a nibble read port has several select bits set, its output is the bitwise OR of the selected registers.
- R5: With forwarding on, a nibble read of a register that is written in the same cycle returns the incoming write data of the winning writer.
- R6: When `wwr_en` is high at a rising edge and no nibble port writes, register i takes bits 4i+3:4i of `wwr_data`.
- R7: The word read port returns register i in bits 4i+3:4i while `wrd_en` is high, and returns 0 while `wrd_en` is low.
- R8: When the word write and a nibble write hit the same register in one cycle, that register takes the nibble data. Registers not hit by any nibble port take the word data.
- R9: When several nibble write ports hit the same register in one cycle, the port with the lowest number wins.
- R10: The word read forwards nibble by nibble. Each register being written in the current cycle shows its incoming data, and every other register shows its stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| nwr_sel | input | 64 | Write selects; bit p*8+i makes nibble port p write register i |
| nwr_data | input | 32 | Write data; bits 4p+3:4p belong to nibble write port p |
| nrd_sel | input | 64 | Read selects; bit p*8+i makes nibble read port p select register i |
| nrd_data | output | 32 | Read data; bits 4p+3:4p belong to nibble read port p |
| wwr_en | input | 1 | Word write enable |
| wwr_data | input | 32 | Word write data, register i in bits 4i+3:4i |
| wrd_en | input | 1 | Word read enable |
| wrd_data | output | 32 | Word read data, register i in bits 4i+3:4i |

## Verification
Some properties are checked by assertions on every cycle:
- the reset clear;
- the priority of port 0 over every other writer;
- the word write landing on registers that no nibble port touched;
- zero output from idle read ports.

Other behaviours only show up in the bench's scenarios, which compare every read output against a model:
- OR-combining of multiple read selects;
- same-cycle forwarding through both nibble and word ports;
- priority between two non-zero nibble ports.

// File: rtl/snrf_pkg.sv
package snrf_pkg;

    // Default geometry of the split file.
    localparam int SNRF_NREG  = 8;
    localparam int SNRF_NW    = 4;
    localparam int SNRF_NPORT = 8;

    // Source chosen by a cell's write arbiter.
    typedef enum logic [1:0] {
        SRC_HOLD   = 2'd0,
        SRC_NIBBLE = 2'd1,
        SRC_WORD   = 2'd2
    } snrf_src_e;

endpackage

// File: rtl/snrf_cell.sv
module snrf_cell
    import snrf_pkg::*;
#(
    parameter int NW         = SNRF_NW,
    parameter int NPORT      = SNRF_NPORT,
    parameter bit WRITE_THRU = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NPORT-1:0]    wsel,
    input  logic [NPORT*NW-1:0] wdata,
    input  logic                word_we,
    input  logic [NW-1:0]       word_wd,
    output logic [NW-1:0]       q,
    output logic [NW-1:0]       fwd
);

    snrf_src_e   src;
    logic [NW-1:0] pick;

    // Arbitration: word write is the fallback; scanning nibble ports from the
    // top down leaves the lowest-numbered selecting port as the winner.
    always_comb begin
        pick = word_wd;
        src  = word_we ? SRC_WORD : SRC_HOLD;
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (wsel[p]) begin
                pick = wdata[p*NW +: NW];
                src  = SRC_NIBBLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (src)
                SRC_NIBBLE, SRC_WORD: q <= pick;
                default:              q <= q;
            endcase
        end
    end

    generate
        if (WRITE_THRU) begin : g_fwd
            always_comb fwd = (src != SRC_HOLD) ? pick : q;
        end else begin : g_nofwd
            always_comb fwd = q;
        end
    endgenerate

    // R1
    rst_clear_chk: assert property (@(posedge clk) rst |=> q == '0);

    // R9
    port0_wins_chk: assert property (@(posedge clk) disable iff (rst)
        wsel[0] |=> q == $past(wdata[NW-1:0]));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wsel == '0 && !word_we) |=> $stable(q));

endmodule

// File: rtl/snrf_rmux.sv
module snrf_rmux
    import snrf_pkg::*;
#(
    parameter int NREG = SNRF_NREG,
    parameter int NW   = SNRF_NW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NREG-1:0]    sel,
    input  logic [NREG*NW-1:0] vals,
    output logic [NW-1:0]      dout
);

    // OR of all selected registers; empty select yields zero.
    always_comb begin
        dout = '0;
        for (int i = 0; i < NREG; i++) begin
            if (sel[i]) dout = dout | vals[i*NW +: NW];
        end
    end

    // R3
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        sel == '0 |-> dout == '0);

endmodule

// File: rtl/snrf_regfile.sv
module snrf_regfile
    import snrf_pkg::*;
#(
    parameter int NREG       = SNRF_NREG,
    parameter int NW         = SNRF_NW,
    parameter int NPORT      = SNRF_NPORT,
    parameter bit WRITE_THRU = 1'b1,
    localparam int WORDW     = NREG * NW,
    localparam int SELW      = NPORT * NREG,
    localparam int PDW       = NPORT * NW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SELW-1:0]  nwr_sel,
    input  logic [PDW-1:0]   nwr_data,
    input  logic [SELW-1:0]  nrd_sel,
    output logic [PDW-1:0]   nrd_data,
    input  logic             wwr_en,
    input  logic [WORDW-1:0] wwr_data,
    input  logic             wrd_en,
    output logic [WORDW-1:0] wrd_data
);

    logic [NREG-1:0][NPORT-1:0] cell_sel;
    logic [WORDW-1:0]           stored;
    logic [WORDW-1:0]           view;

    genvar gi, gp;
    generate
        for (gi = 0; gi < NREG; gi++) begin : g_cell
            for (gp = 0; gp < NPORT; gp++) begin : g_tap
                assign cell_sel[gi][gp] = nwr_sel[gp*NREG + gi];
            end

            snrf_cell #(
                .NW(NW), .NPORT(NPORT), .WRITE_THRU(WRITE_THRU)
            ) cell_i (
                .clk     (clk),
                .rst     (rst),
                .wsel    (cell_sel[gi]),
                .wdata   (nwr_data),
                .word_we (wwr_en),
                .word_wd (wwr_data[gi*NW +: NW]),
                .q       (stored[gi*NW +: NW]),
                .fwd     (view[gi*NW +: NW])
            );

            // R8
            word_fill_chk: assert property (@(posedge clk) disable iff (rst)
                (wwr_en && cell_sel[gi] == '0) |=>
                    stored[gi*NW +: NW] == $past(wwr_data[gi*NW +: NW]));
        end

        for (gp = 0; gp < NPORT; gp++) begin : g_rport
            snrf_rmux #(.NREG(NREG), .NW(NW)) rmux_i (
                .clk  (clk),
                .rst  (rst),
                .sel  (nrd_sel[gp*NREG +: NREG]),
                .vals (view),
                .dout (nrd_data[gp*NW +: NW])
            );
        end
    endgenerate

    assign wrd_data = wrd_en ? view : '0;

    // R7
    word_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !wrd_en |-> wrd_data == '0);

endmodule

// File: tb/snrf_regfile_tb_top.sv
module snrf_regfile_tb_top;

    localparam int NREG = 8;
    localparam int NW   = 4;
    localparam int NP   = 8;
    localparam int WW   = NREG * NW;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst;
    logic [NP*NREG-1:0] nwr_sel, nrd_sel;
    logic [NP*NW-1:0] nwr_data, nrd_data;
    logic             wwr_en, wrd_en;
    logic [WW-1:0]    wwr_data, wrd_data;

    int nvec = 0;
    int nmis = 0;
    logic [NW-1:0] mdl [NREG];

    snrf_regfile dut_i (
        .clk(clk), .rst(rst),
        .nwr_sel(nwr_sel), .nwr_data(nwr_data),
        .nrd_sel(nrd_sel), .nrd_data(nrd_data),
        .wwr_en(wwr_en), .wwr_data(wwr_data),
        .wrd_en(wrd_en), .wrd_data(wrd_data)
    );

    function automatic bit wr_hit(int i);
        for (int p = 0; p < NP; p++) if (nwr_sel[p*NREG + i]) return 1'b1;
        return wwr_en;
    endfunction

    function automatic logic [NW-1:0] wr_val(int i);
        for (int p = 0; p < NP; p++)
            if (nwr_sel[p*NREG + i]) return nwr_data[p*NW +: NW];
        return wwr_data[i*NW +: NW];
    endfunction

    function automatic logic [NW-1:0] fwd_val(int i);
        return wr_hit(i) ? wr_val(i) : mdl[i];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nmis++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        nwr_sel = '0; nrd_sel = '0; nwr_data = '0;
        wwr_en = 1'b0; wwr_data = '0; wrd_en = 1'b1;
    endtask

    // Called just after a falling edge with inputs applied.
    task automatic step(bit do_chk, string wtag);
        logic [NW-1:0] nxt [NREG];
        logic [WW-1:0] wexp;
        bit anyw;
        #1;
        if (do_chk) begin
            anyw = 1'b0;
            for (int i = 0; i < NREG; i++) begin
                wexp[i*NW +: NW] = fwd_val(i);
                if (wr_hit(i)) anyw = 1'b1;
            end
            if (!wrd_en) wexp = '0;
            chk(wtag != "" ? wtag : (!wrd_en ? "R7" : (anyw ? "R10" : "R7")),
                wrd_data, wexp);
            for (int p = 0; p < NP; p++) begin
                logic [NW-1:0] e = '0;
                int cnt = 0;
                bit fw = 1'b0;
                for (int i = 0; i < NREG; i++) begin
                    if (nrd_sel[p*NREG + i]) begin
                        e |= fwd_val(i); cnt++;
                        if (wr_hit(i)) fw = 1'b1;
                    end
                end
                chk(cnt == 0 ? "R3" : (cnt > 1 ? "R4" : (fw ? "R5" : "R2")),
                    {28'd0, nrd_data[p*NW +: NW]}, {28'd0, e});
            end
        end
        for (int i = 0; i < NREG; i++) nxt[i] = rst ? '0 : fwd_val(i);
        @(posedge clk);
        for (int i = 0; i < NREG; i++) mdl[i] = nxt[i];
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        nmis++;
        $display("watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        idle();
        rst = 1'b1;
        for (int i = 0; i < NREG; i++) mdl[i] = '0;
        @(negedge clk);
        step(1'b0, "");
        step(1'b0, "");
        rst = 1'b0;
        step(1'b1, "R1");

        // R6: word write alone, then read back through word and nibble ports
        wwr_en = 1'b1; wwr_data = 32'hA5C3_9E17;
        step(1'b1, "");
        idle();
        nrd_sel = 64'h8040_2010_0804_0201;
        step(1'b1, "R6");

        // R9: ports 3 and 6 both write register 2; port 3 must win
        idle();
        nwr_sel[3*NREG + 2] = 1'b1; nwr_data[3*NW +: NW] = 4'h6;
        nwr_sel[6*NREG + 2] = 1'b1; nwr_data[6*NW +: NW] = 4'hB;
        step(1'b1, "R9");
        idle();
        step(1'b1, "R9");

        // R8: word write collides with nibble port 5 on register 6
        nwr_sel[5*NREG + 6] = 1'b1; nwr_data[5*NW +: NW] = 4'h1;
        wwr_en = 1'b1; wwr_data = 32'h7777_7777;
        step(1'b1, "R8");
        idle();
        step(1'b1, "R8");

        // R7: word read disabled
        wrd_en = 1'b0;
        step(1'b1, "R7");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            for (int p = 0; p < NP; p++) begin
                int r = $urandom % 4;
                nwr_sel[p*NREG +: NREG] = (r == 0) ? 8'h00 :
                    (r == 3) ? 8'($urandom) : 8'(1 << ($urandom % NREG));
                if ($urandom % 3 != 0) nwr_sel[p*NREG +: NREG] = 8'h00;
                r = $urandom % 4;
                nrd_sel[p*NREG +: NREG] = (r == 0) ? 8'h00 :
                    (r == 3) ? 8'($urandom) : 8'(1 << ($urandom % NREG));
            end
            nwr_data = $urandom;
            wwr_en   = ($urandom % 3) == 0;
            wwr_data = $urandom;
            wrd_en   = ($urandom % 5) != 0;
            rst      = ($urandom % 250) == 0;
            step(1'b1, "");
            if (rst) begin
                rst = 1'b0;
                idle();
                step(1'b1, "R1");
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end

endmodule